// File: doc/BRIEF.md
# I2S Master Clock Generator

This block produces every timing signal that an audio serial master needs, all from a single kernel clock: the serial bit clock, the left/right word-select line and an optional oversampling master clock for an external converter. A companion data shifter does not need to decode the clock waveforms. It uses two single-cycle strobes instead. One marks every bit boundary, where serial data changes. The other marks every channel change.

Software programs an 8-bit prescaler value, a half-step adjust bit, a master-clock enable, the idle polarity of the bit clock and the channel length (16 or 32 bits). When the master clock is driven, the bit clock is a fixed sub-multiple of it, so the master clock runs at 256 times the sample rate. When it is not driven, the prescaler output is used directly as the bit clock. Raising the enable starts a frame with one lead-in bit. Clearing the enable lets the current stereo frame run to completion before every output returns to idle.

Top module: `i2s_clkgen`

## Requirements
- R1: The division factor N equals 2·DIV+ODD, where DIV is `div_i` and ODD is `odd_i`. A DIV value of 0 or 1 is treated as 2 and ODD is then ignored, so N = 4.
- R2: With the master clock disabled and polarity 0, `ck_o` has a period of N kernel cycles. It is high for floor(N/2) of those cycles.
- R3: With `mck_en_i` = 1, `mck_o` has a period of N cycles and is high for ceil(N/2) of them. With `mck_en_i` = 0, `mck_o` stays 0.
- R4: With the master clock enabled, the `ck_o` period is 8·N for 16-bit channels (`ch32_i` = 0) and 4·N for 32-bit channels (`ch32_i` = 1).
- R5: When idle, `ck_o` equals `ck_pol_i`. While running, every `bit_stb_o` cycle shows `ck_o` at the `ck_pol_i` level. With polarity 0 this means data changes on a falling edge.
- R6: A channel lasts 16 bit periods (`ch32_i` = 0) or 32 bit periods (`ch32_i` = 1). `ws_o` toggles only in a cycle where both `chan_stb_o` and `bit_stb_o` are 1. That cycle is the start of the last bit of the old channel, one bit before the MSB of the next channel.
- R7: After a start, `ws_o` is 0 (left channel). The first `chan_stb_o` falls on the 16th or 32nd `bit_stb_o`, because one lead-in bit precedes the left MSB.
- R8: Once `enable` is cleared, the block keeps running until the bit boundary that ends the right-channel LSB. It then goes idle: `ck_o` at polarity, `ws_o` = 0, `mck_o` = 0 and no strobes. A start is always followed by at least one whole frame.
- R9: The configuration inputs are captured only while idle. Changes made while running take no effect until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Start request; clearing it stops the block at the end of the frame |
| div_i | input | 8 | Prescaler value DIV |
| odd_i | input | 1 | Half-step adjust, adds one kernel cycle to N |
| mck_en_i | input | 1 | Drive the master clock; the bit clock becomes MCK/8 or MCK/4 |
| ck_pol_i | input | 1 | Idle level of the bit clock |
| ch32_i | input | 1 | 0: 16-bit channels, 1: 32-bit channels |
| mck_o | output | 1 | Master clock |
| ck_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word select, 0 = left, 1 = right |
| bit_stb_o | output | 1 | One-cycle pulse at each bit boundary |
| chan_stb_o | output | 1 | One-cycle pulse when word select changes |

## Verification
The divider is run with even and odd factors, with illegal prescaler values 0 and 1 (with ODD set), and with a large factor. Measuring high and low times on odd factors shows the half-step split, and the illegal values show that ODD is dropped. The same factors are repeated with the master clock on, at both channel lengths. This separates the 8·N and 4·N bit ratios and confirms that the master clock keeps period N. Separate runs cover the other behaviours: a lead-in count, a disable issued at a left-channel change, a one-cycle enable pulse, inverted polarity, and a configuration change made mid-run. Together they show the frame-boundary stop, the idle levels and the capture of the configuration.

// File: rtl/i2s_clkgen_pkg.sv
`timescale 1ns/1ps
package i2s_clkgen_pkg;

    // prescaler field and divider counter widths
    localparam int PRE_W   = 8;
    localparam int CNT_W   = PRE_W + 1;
    localparam int PRE_MIN = 2;

    // channel lengths in bit periods
    localparam int CH_SHORT = 16;
    localparam int CH_LONG  = 32;
    localparam int BIT_W    = $clog2(CH_LONG);

    // master-clock periods per half bit: 4 gives MCK/8, 2 gives MCK/4
    localparam int MHALF_SHORT = 4;
    localparam int MHALF_LONG  = 2;
    localparam int MH_W        = $clog2(MHALF_SHORT);

    typedef struct packed {
        logic [PRE_W-1:0] div;
        logic             odd;
        logic             mck_en;
        logic             ck_pol;
        logic             ch32;
    } clk_cfg_t;

    // total division 2*DIV+ODD, with illegal small values forced to 4
    function automatic logic [CNT_W-1:0] total_div(input logic [PRE_W-1:0] d,
                                                   input logic             o);
        logic [CNT_W-1:0] r;
        if (d < PRE_W'(PRE_MIN))
            r = CNT_W'(2 * PRE_MIN);
        else
            r = {d, 1'b0} + CNT_W'(o);
        return r;
    endfunction

    // length of the first (high) phase: ceil(n/2)
    function automatic logic [CNT_W-1:0] high_len(input logic [CNT_W-1:0] n);
        logic [CNT_W:0] t;
        t = {1'b0, n} + 1'b1;
        return t[CNT_W:1];
    endfunction

    function automatic logic [BIT_W-1:0] last_bit(input logic ch32);
        return ch32 ? BIT_W'(CH_LONG - 1) : BIT_W'(CH_SHORT - 1);
    endfunction

    function automatic logic [MH_W-1:0] half_last(input logic ch32);
        return ch32 ? MH_W'(MHALF_LONG - 1) : MH_W'(MHALF_SHORT - 1);
    endfunction

endpackage

// File: rtl/i2s_clkgen_prescaler.sv
`timescale 1ns/1ps
module i2s_clkgen_prescaler
    import i2s_clkgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [PRE_W-1:0] div,
    input  logic             odd,
    output logic             rise_ev,
    output logic             fall_ev,
    output logic             hi_q
);
    logic [CNT_W-1:0] n_div;
    logic [CNT_W-1:0] n_high;
    logic [CNT_W-1:0] cnt_q;

    assign n_div   = total_div(div, odd);
    assign n_high  = high_len(n_div);
    assign rise_ev = (cnt_q == n_div - 1'b1);
    assign fall_ev = (cnt_q == n_high - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
            hi_q  <= 1'b1;
        end else begin
            cnt_q <= rise_ev ? '0 : cnt_q + 1'b1;
            if (rise_ev)
                hi_q <= 1'b1;
            else if (fall_ev)
                hi_q <= 1'b0;
        end
    end

    // R1: the counter never runs past the programmed division
    p_cnt_range_r1: assert property (@(posedge clk) disable iff (rst)
        cnt_q < n_div);

endmodule

// File: rtl/i2s_clkgen_bitclk.sv
`timescale 1ns/1ps
module i2s_clkgen_bitclk
    import i2s_clkgen_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic rise_ev,
    input  logic fall_ev,
    input  logic mck_mode,
    input  logic ch32,
    output logic ph_q,
    output logic boundary
);
    logic [MH_W-1:0] mcnt_q;
    logic [MH_W-1:0] mlast;
    logic            half;

    assign mlast = half_last(ch32);

    generate
        if (MHALF_SHORT > 1) begin : g_ratio
            // master-clock mode toggles every mlast+1 MCK periods, else on both prescaler edges
            assign half = mck_mode ? (rise_ev && (mcnt_q == mlast)) : (rise_ev || fall_ev);
        end else begin : g_direct
            assign half = rise_ev || fall_ev;
        end
    endgenerate

    assign boundary = half && ph_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ph_q   <= 1'b0;
            mcnt_q <= '0;
        end else begin
            if (rise_ev)
                mcnt_q <= (mcnt_q == mlast) ? '0 : mcnt_q + 1'b1;
            if (half)
                ph_q <= ~ph_q;
        end
    end

    // R4: the master-clock sub-counter stays inside the selected ratio
    p_mcnt_range_r4: assert property (@(posedge clk) disable iff (rst)
        mcnt_q <= mlast);

endmodule

// File: rtl/i2s_clkgen_framer.sv
`timescale 1ns/1ps
module i2s_clkgen_framer
    import i2s_clkgen_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic boundary,
    input  logic ch32,
    output logic ws_q,
    output logic bit_stb_q,
    output logic chan_stb_q,
    output logic frame_end
);
    logic [BIT_W-1:0] bcnt_q;
    logic [BIT_W-1:0] bnext;
    logic [BIT_W-1:0] last;
    logic             first_q;

    assign last      = last_bit(ch32);
    assign bnext     = (first_q || bcnt_q == last) ? '0 : bcnt_q + 1'b1;
    assign frame_end = boundary && !first_q && !ws_q && (bcnt_q == last);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            bcnt_q     <= '0;
            first_q    <= 1'b1;
            ws_q       <= 1'b0;
            bit_stb_q  <= 1'b0;
            chan_stb_q <= 1'b0;
        end else begin
            bit_stb_q  <= boundary;
            chan_stb_q <= boundary && (bnext == last);
            if (boundary) begin
                bcnt_q  <= bnext;
                first_q <= 1'b0;
                if (bnext == last)
                    ws_q <= ~ws_q;
            end
        end
    end

    // R6: word select moves only together with the channel strobe
    p_ws_move_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(ws_q) |-> chan_stb_q);
    // R6: a channel change always sits on a bit boundary
    p_chan_bit_r6: assert property (@(posedge clk) disable iff (rst)
        chan_stb_q |-> bit_stb_q);
    // R6: bit index stays inside the channel
    p_bcnt_range_r6: assert property (@(posedge clk) disable iff (rst)
        bcnt_q <= last);

endmodule

// File: rtl/i2s_clkgen.sv
`timescale 1ns/1ps
module i2s_clkgen
    import i2s_clkgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [PRE_W-1:0] div_i,
    input  logic             odd_i,
    input  logic             mck_en_i,
    input  logic             ck_pol_i,
    input  logic             ch32_i,
    output logic             mck_o,
    output logic             ck_o,
    output logic             ws_o,
    output logic             bit_stb_o,
    output logic             chan_stb_o
);
    clk_cfg_t cfg_q;
    logic     run_q;
    logic     start;
    logic     stop;
    logic     clr;
    logic     rise_ev;
    logic     fall_ev;
    logic     hi_q;
    logic     ph_q;
    logic     boundary;
    logic     frame_end;

    assign start = !run_q && enable;
    assign stop  = run_q && frame_end && !enable;
    assign clr   = !run_q || stop;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cfg_q <= '0;
        end else begin
            if (!run_q)
                cfg_q <= clk_cfg_t'{div: div_i, odd: odd_i, mck_en: mck_en_i,
                                    ck_pol: ck_pol_i, ch32: ch32_i};
            if (start)
                run_q <= 1'b1;
            else if (stop)
                run_q <= 1'b0;
        end
    end

    i2s_clkgen_prescaler u_pre (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .div     (cfg_q.div),
        .odd     (cfg_q.odd),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev),
        .hi_q    (hi_q)
    );

    i2s_clkgen_bitclk u_bck (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .rise_ev  (rise_ev),
        .fall_ev  (fall_ev),
        .mck_mode (cfg_q.mck_en),
        .ch32     (cfg_q.ch32),
        .ph_q     (ph_q),
        .boundary (boundary)
    );

    i2s_clkgen_framer u_frm (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .boundary   (boundary),
        .ch32       (cfg_q.ch32),
        .ws_q       (ws_o),
        .bit_stb_q  (bit_stb_o),
        .chan_stb_q (chan_stb_o),
        .frame_end  (frame_end)
    );

    assign mck_o = run_q && cfg_q.mck_en && hi_q;
    assign ck_o  = run_q ? (ph_q ^ cfg_q.ck_pol) : cfg_q.ck_pol;

    // R8: idle means quiet outputs at the programmed levels
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !run_q |-> (ck_o == cfg_q.ck_pol && !mck_o && !ws_o && !bit_stb_o && !chan_stb_o));
    // R8: leaving the running state needs a cleared enable
    p_stop_needs_off_r8: assert property (@(posedge clk) disable iff (rst)
        ($fell(run_q) && !$past(rst)) |-> !$past(enable));
    // R3: no master clock unless enabled
    p_mck_gate_r3: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.mck_en |-> !mck_o);
    // R5: bit boundaries land on the idle level of the bit clock
    p_bit_level_r5: assert property (@(posedge clk) disable iff (rst)
        bit_stb_o |-> (ck_o == cfg_q.ck_pol));
    // R9: configuration frozen while running
    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (run_q && $past(run_q)) |-> $stable(cfg_q));

endmodule

// File: tb/i2s_clkgen_bench.sv
`timescale 1ns/1ps
module i2s_clkgen_bench;
    import i2s_clkgen_pkg::*;

    localparam int WDOG = 150000;
    localparam int NV   = 8;

    typedef struct packed {
        logic [7:0]  div;
        logic        odd;
        logic        mck;
        logic        ch32;
        logic [15:0] per;
        logic [15:0] high;
        logic [15:0] mper;
    } vec_t;

    // div, odd, mck, ch32, ck period, ck high time, mck period
    localparam vec_t VECS [NV] = '{
        '{8'd2,  1'b0, 1'b0, 1'b0, 16'd4,  16'd2,  16'd0},  // R2 even N
        '{8'd3,  1'b1, 1'b0, 1'b0, 16'd7,  16'd3,  16'd0},  // R2 odd N split
        '{8'd0,  1'b1, 1'b0, 1'b0, 16'd4,  16'd2,  16'd0},  // R1 illegal 0, odd dropped
        '{8'd1,  1'b0, 1'b0, 1'b1, 16'd4,  16'd2,  16'd0},  // R1 illegal 1
        '{8'd2,  1'b1, 1'b1, 1'b0, 16'd40, 16'd20, 16'd5},  // R4 MCK/8
        '{8'd3,  1'b0, 1'b1, 1'b1, 16'd24, 16'd12, 16'd6},  // R4 MCK/4
        '{8'd1,  1'b1, 1'b1, 1'b0, 16'd32, 16'd16, 16'd4},  // R1 illegal with MCK
        '{8'd10, 1'b1, 1'b0, 1'b1, 16'd21, 16'd10, 16'd0}   // R2 large N
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic [7:0] div_i = 8'd2;
    logic       odd_i = 1'b0;
    logic       mck_en_i = 1'b0;
    logic       ck_pol_i = 1'b0;
    logic       ch32_i = 1'b0;
    logic       mck_o, ck_o, ws_o, bit_stb_o, chan_stb_o;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    i2s_clkgen u_i2s_clkgen (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .div_i      (div_i),
        .odd_i      (odd_i),
        .mck_en_i   (mck_en_i),
        .ck_pol_i   (ck_pol_i),
        .ch32_i     (ch32_i),
        .mck_o      (mck_o),
        .ck_o       (ck_o),
        .ws_o       (ws_o),
        .bit_stb_o  (bit_stb_o),
        .chan_stb_o (chan_stb_o)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc == WDOG) begin
            errors = errors + 1;
            $display("FAIL watchdog actual %0d expected below %0d cycles", cyc, WDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check_eq(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // wait for a transition of ck (sel=0) or mck (sel=1) to level lvl
    task automatic wait_edge(input bit sel, input logic lvl);
        logic p;
        bit   done;
        done = 1'b0;
        p = sel ? mck_o : ck_o;
        while (!done) begin
            @(negedge clk);
            if ((sel ? mck_o : ck_o) == lvl && p != lvl)
                done = 1'b1;
            p = sel ? mck_o : ck_o;
        end
    endtask

    task automatic measure(input bit sel, output int per, output int high);
        int t0;
        int t1;
        wait_edge(sel, 1'b1);
        t0 = cyc;
        wait_edge(sel, 1'b0);
        t1 = cyc;
        wait_edge(sel, 1'b1);
        high = t1 - t0;
        per = cyc - t0;
    endtask

    task automatic count_channel(output int bits, output int flipped);
        logic w0;
        bit   done;
        done = 1'b0;
        while (chan_stb_o !== 1'b1) @(negedge clk);
        w0 = ws_o;
        bits = 0;
        while (!done) begin
            @(negedge clk);
            if (bit_stb_o) bits = bits + 1;
            if (chan_stb_o) done = 1'b1;
        end
        flipped = (ws_o != w0) ? 1 : 0;
    endtask

    task automatic count_rises(input int window, output int rises, output int chans);
        logic p;
        p = ck_o;
        rises = 0;
        chans = 0;
        for (int k = 0; k < window; k++) begin
            @(negedge clk);
            if (ck_o && !p) rises = rises + 1;
            if (chan_stb_o) chans = chans + 1;
            p = ck_o;
        end
    endtask

    task automatic setup(input logic [7:0] d, input logic o, input logic m,
                         input logic c32, input logic pol);
        div_i = d;
        odd_i = o;
        mck_en_i = m;
        ch32_i = c32;
        ck_pol_i = pol;
        tick(3);
    endtask

    task automatic check_idle(input string req, input logic pol);
        check_eq({req, " idle ck"}, int'(ck_o), int'(pol));
        check_eq({req, " idle ws"}, int'(ws_o), 0);
        check_eq({req, " idle mck"}, int'(mck_o), 0);
        check_eq({req, " idle strobes"}, int'(bit_stb_o | chan_stb_o), 0);
    endtask

    initial begin
        int per;
        int high;
        int bits;
        int flip;
        int rises;
        int chans;
        int bad;
        int seen;
        vec_t v;

        tick(4);
        rst = 1'b0;
        tick(2);
        // R5 R8: state after reset
        check_idle("R5 R8 after reset", 1'b0);

        // table walk: R1 R2 R3 R4 R6 R8
        for (int i = 0; i < NV; i++) begin
            v = VECS[i];
            setup(v.div, v.odd, v.mck, v.ch32, 1'b0);
            enable = 1'b1;
            measure(1'b0, per, high);
            check_eq(v.mck ? "R4 bit period" : "R1/R2 bit period", per, int'(v.per));
            check_eq(v.mck ? "R4 bit high time" : "R2 bit high time", high, int'(v.high));
            if (v.mck) begin
                measure(1'b1, per, high);
                check_eq("R3 mck period", per, int'(v.mper));
                check_eq("R3 mck high time", high, (int'(v.mper) + 1) / 2);
            end else begin
                seen = 0;
                for (int k = 0; k < 3 * int'(v.per); k++) begin
                    @(negedge clk);
                    if (mck_o) seen = seen + 1;
                end
                check_eq("R3 mck held low", seen, 0);
            end
            count_channel(bits, flip);
            check_eq("R6 bits per channel", bits, v.ch32 ? CH_LONG : CH_SHORT);
            check_eq("R6 ws toggled at channel strobe", flip, 1);
            enable = 1'b0;
            tick(4 * (v.ch32 ? CH_LONG : CH_SHORT) * int'(v.per) + 40);
            check_idle("R8 after disable", 1'b0);
        end

        // R7: lead-in bit before the left MSB
        setup(8'd2, 1'b0, 1'b0, 1'b0, 1'b0);
        enable = 1'b1;
        bits = 0;
        bad = 0;
        while (chan_stb_o !== 1'b1) begin
            @(negedge clk);
            if (bit_stb_o) bits = bits + 1;
            if (ws_o && !chan_stb_o) bad = bad + 1;
        end
        check_eq("R7 bit strobes up to first channel strobe", bits, CH_SHORT);
        check_eq("R7 ws low before first change", bad, 0);
        check_eq("R7 first change goes right", int'(ws_o), 1);

        // R8: disable right after ws rose; finish the frame (17 rising edges)
        enable = 1'b0;
        count_rises(300, rises, chans);
        check_eq("R8 rises after disable at left LSB", rises, CH_SHORT + 1);
        check_eq("R8 ws changes before stop", chans, 1);
        check_idle("R8 after frame end", 1'b0);

        // R8: single-cycle enable still produces one whole frame
        enable = 1'b1;
        tick(1);
        enable = 1'b0;
        count_rises(400, rises, chans);
        check_eq("R8 one-cycle enable rises", rises, 2 * CH_SHORT + 1);
        check_eq("R8 one-cycle enable channel strobes", chans, 2);
        check_idle("R8 one-cycle enable end", 1'b0);

        // R5: inverted polarity
        setup(8'd2, 1'b0, 1'b0, 1'b0, 1'b1);
        check_eq("R5 idle ck with polarity 1", int'(ck_o), 1);
        enable = 1'b1;
        bad = 0;
        seen = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (bit_stb_o) begin
                seen = seen + 1;
                if (!ck_o) bad = bad + 1;
            end
        end
        check_eq("R5 ck level at bit strobes", bad, 0);
        check_eq("R5 bit strobes seen", int'(seen > 0), 1);
        enable = 1'b0;
        tick(400);
        check_idle("R5 R8 idle with polarity 1", 1'b1);

        // R9: changes while running are ignored until the next start
        setup(8'd2, 1'b0, 1'b0, 1'b0, 1'b0);
        enable = 1'b1;
        tick(10);
        div_i = 8'd10;
        mck_en_i = 1'b1;
        measure(1'b0, per, high);
        check_eq("R9 period unchanged while running", per, 4);
        enable = 1'b0;
        tick(400);
        check_eq("R9 mck still off after run", int'(mck_o), 0);
        enable = 1'b1;
        measure(1'b0, per, high);
        check_eq("R9 new config after restart", per, 8 * 20);
        enable = 1'b0;
        tick(4 * CH_SHORT * 160 + 40);
        check_idle("R9 R8 final", 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule